// File: doc/BRIEF.md
# Event-to-Virtual-Interrupt Aggregator

This block turns numbered event messages into level interrupt lines. Each arriving event carries a global event number. A programmable routing table looks that number up and finds one virtual interrupt and one bit position inside it. The event then sets that status bit. Each virtual interrupt keeps a 64-bit raw status word and a 64-bit enable word. It drives one active-high line, which is high while any enabled status bit is set.

Software works through a plain 64-bit register read/write port. Bank n starts at n × 0x1000. Inside each bank, enables are set and cleared at separate write-one addresses, edge-type status bits are acknowledged by writing ones, and the masked status is readable as a single word. Routing entries sit in a separate range, selected by the top address bit.

Sources that signal a level send a later "down" event, which clears their bit. Edge-type bits are cleared only by software acknowledge. When an event set and a clear hit the same bit in the same cycle, the set takes priority.

Top module: `evt_aggr_top`

## Requirements
- R1: After reset, every status word, enable word and level flag is zero, every routing entry is invalid, and every `irq_o` bit is low.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1. Write-data bits that are 0 leave their enable bits unchanged. A read at offset 0x0 or 0x8 returns the enable word.
- R3: A write to bank offset 0x8 clears each enable bit whose write-data bit is 1.
- R4: An event (`evt_valid_i`=1, `evt_down_i`=0) whose routing entry is valid and whose virtual interrupt index is below NUM_VINT sets the routed status bit at the next clock edge. Reading offset 0x18 returns the raw status word.
- R5: An event is dropped, and changes no status, when its entry has valid=0 or names a virtual interrupt index at or above NUM_VINT.
- R6: Writing ones to offset 0x18 clears the edge-type status bits at those positions. Level-type bits at those positions are unaffected.
- R7: A down event (`evt_down_i`=1) whose entry is level-type clears the routed status bit. A down event whose entry is edge-type has no effect.
- R8: A read at offset 0x20 returns raw status AND enable. Writes to offset 0x20 have no effect.
- R9: `irq_o[n]` is high exactly when bank n has at least one bit set in both status and enable. It reflects the state in the same cycle that state changes.
- R10: If an event set and a software acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R11: Routing entry e is at address 0x10000 + 8·e, with fields bit index [5:0], virtual interrupt index [15:8], level flag [16] and valid [31]. A read returns those fields and zeros elsewhere. A valid write whose index is in range also sets the level/edge type of the target status bit.
- R12: Banks are independent. Bit 63 is fully usable, and an access to bank n changes no other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event message present this cycle |
| evt_num_i | input | $clog2(NUM_EVT) | Global event number |
| evt_down_i | input | 1 | Event is a level-source down message |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational from address) |
| irq_o | output | NUM_VINT | Level interrupt per virtual interrupt |

## Verification
Every event and register write takes effect at the first rising edge that samples it. Raw status, enable, masked status and `irq_o` all change right after that edge, with no further pipeline stage. Read data follows the address combinationally from the stored state, so a read is correct in the same cycle once the address settles. The bench drives inputs on the falling edge and updates its reference model at the rising edge. On every falling edge it compares `irq_o` against the model, and it checks readbacks one time step after it places the address, so each result is checked in exactly the cycle it becomes due.

// File: rtl/evt_aggr_pkg.sv
package evt_aggr_pkg;
  localparam int unsigned BANK_W = 64;
  localparam int unsigned BIT_W  = 6;

  localparam logic [11:0] OFF_EN_SET = 12'h000;
  localparam logic [11:0] OFF_EN_CLR = 12'h008;
  localparam logic [11:0] OFF_RAW    = 12'h018;
  localparam logic [11:0] OFF_MASKED = 12'h020;

  typedef struct packed {
    logic             valid;
    logic             level;
    logic [7:0]       vint;
    logic [BIT_W-1:0] bitpos;
  } map_entry_t;

  function automatic map_entry_t word_to_entry(input logic [31:0] w);
    map_entry_t e;
    e.valid  = w[31];
    e.level  = w[16];
    e.vint   = w[15:8];
    e.bitpos = w[BIT_W-1:0];
    return e;
  endfunction

  function automatic logic [BANK_W-1:0] entry_to_word(input map_entry_t e);
    logic [BANK_W-1:0] w;
    w = '0;
    w[31]          = e.valid;
    w[16]          = e.level;
    w[15:8]        = e.vint;
    w[BIT_W-1:0]   = e.bitpos;
    return w;
  endfunction
endpackage

// File: rtl/evt_map_table.sv
module evt_map_table
  import evt_aggr_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 16,
  parameter int unsigned NUM_VINT = 4,
  localparam int unsigned EW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
  localparam int unsigned VW = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [EW-1:0]     wr_idx_i,
  input  logic [31:0]       wr_word_i,
  input  logic [EW-1:0]     rd_idx_i,
  output logic [BANK_W-1:0] rd_word_o,
  input  logic              lk_valid_i,
  input  logic [EW-1:0]     lk_num_i,
  output logic              lk_hit_o,
  output logic [VW-1:0]     lk_vint_o,
  output logic [BIT_W-1:0]  lk_bit_o,
  output logic              lk_level_o
);
  map_entry_t tbl_q [NUM_EVT];
  map_entry_t lk_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_EVT; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= word_to_entry(wr_word_i);
    end
  end

  assign rd_word_o  = entry_to_word(tbl_q[rd_idx_i]);
  assign lk_ent     = tbl_q[lk_num_i];
  // out-of-range vint index drops the event
  assign lk_hit_o   = lk_valid_i && lk_ent.valid && (32'(lk_ent.vint) < NUM_VINT);
  assign lk_vint_o  = lk_ent.vint[VW-1:0];
  assign lk_bit_o   = lk_ent.bitpos;
  assign lk_level_o = lk_ent.level;
endmodule

// File: rtl/evt_vint_bank.sv
module evt_vint_bank
  import evt_aggr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sel_i,
  input  logic [11:0]       wr_off_i,
  input  logic [BANK_W-1:0] wr_data_i,
  input  logic              ev_set_i,
  input  logic              ev_clr_i,
  input  logic [BIT_W-1:0]  ev_bit_i,
  input  logic              lvl_wr_i,
  input  logic [BIT_W-1:0]  lvl_bit_i,
  input  logic              lvl_val_i,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] enable_o,
  output logic              irq_o
);
  logic [BANK_W-1:0] status_q, enable_q, level_q;
  logic [BANK_W-1:0] set_vec, clr_vec, ack_vec, ev_vec;

  assign ev_vec  = BANK_W'(1) << ev_bit_i;
  assign ack_vec = (wr_sel_i && wr_off_i == OFF_RAW) ? (wr_data_i & ~level_q) : '0;
  assign set_vec = ev_set_i ? ev_vec : '0;
  assign clr_vec = ack_vec | (ev_clr_i ? ev_vec : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      level_q  <= '0;
    end else begin
      // set after clear: a same-cycle event wins
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (wr_sel_i && wr_off_i == OFF_EN_SET) enable_q <= enable_q | wr_data_i;
      else if (wr_sel_i && wr_off_i == OFF_EN_CLR) enable_q <= enable_q & ~wr_data_i;
      if (lvl_wr_i) level_q[lvl_bit_i] <= lvl_val_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);
endmodule

// File: rtl/evt_aggr_top.sv
module evt_aggr_top
  import evt_aggr_pkg::*;
#(
  parameter int unsigned NUM_VINT = 4,
  parameter int unsigned NUM_EVT  = 16,
  parameter int unsigned ADDR_W   = 17,
  localparam int unsigned EW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
  localparam int unsigned VW = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_valid_i,
  input  logic [EW-1:0]       evt_num_i,
  input  logic                evt_down_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [BANK_W-1:0]   reg_wdata_i,
  output logic [BANK_W-1:0]   reg_rdata_o,
  output logic [NUM_VINT-1:0] irq_o
);
  logic                         cfg_sel, bank_ok, ent_ok;
  logic [VW-1:0]                bank_idx;
  logic [11:0]                  bank_off;
  logic [EW-1:0]                ent_idx;
  logic                         tbl_wr;
  logic [BANK_W-1:0]            tbl_rd_word;
  logic                         map_hit, map_level;
  logic [VW-1:0]                map_vint;
  logic [BIT_W-1:0]             map_bit;
  logic                         lvl_wr;
  logic [NUM_VINT*BANK_W-1:0]   status_flat, enable_flat;
  logic [BANK_W-1:0]            sel_status, sel_enable;

  assign cfg_sel  = reg_addr_i[ADDR_W-1];
  assign bank_idx = reg_addr_i[12 +: VW];
  assign bank_ok  = 32'(reg_addr_i[ADDR_W-2:12]) < NUM_VINT;
  assign bank_off = reg_addr_i[11:0];
  assign ent_idx  = reg_addr_i[3 +: EW];
  assign ent_ok   = 32'(reg_addr_i[ADDR_W-2:3]) < NUM_EVT;
  assign tbl_wr   = reg_we_i && cfg_sel && ent_ok;
  assign lvl_wr   = tbl_wr && reg_wdata_i[31] && (32'(reg_wdata_i[15:8]) < NUM_VINT);

  evt_map_table #(.NUM_EVT(NUM_EVT), .NUM_VINT(NUM_VINT)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (tbl_wr),
    .wr_idx_i   (ent_idx),
    .wr_word_i  (reg_wdata_i[31:0]),
    .rd_idx_i   (ent_idx),
    .rd_word_o  (tbl_rd_word),
    .lk_valid_i (evt_valid_i),
    .lk_num_i   (evt_num_i),
    .lk_hit_o   (map_hit),
    .lk_vint_o  (map_vint),
    .lk_bit_o   (map_bit),
    .lk_level_o (map_level)
  );

  for (genvar n = 0; n < NUM_VINT; n++) begin : g_bank
    logic here;
    assign here = map_hit && (map_vint == VW'(n));
    evt_vint_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_sel_i  (reg_we_i && !cfg_sel && bank_ok && bank_idx == VW'(n)),
      .wr_off_i  (bank_off),
      .wr_data_i (reg_wdata_i),
      .ev_set_i  (here && !evt_down_i),
      .ev_clr_i  (here && evt_down_i && map_level),
      .ev_bit_i  (map_bit),
      .lvl_wr_i  (lvl_wr && reg_wdata_i[15:8] == 8'(n)),
      .lvl_bit_i (reg_wdata_i[BIT_W-1:0]),
      .lvl_val_i (reg_wdata_i[16]),
      .status_o  (status_flat[n*BANK_W +: BANK_W]),
      .enable_o  (enable_flat[n*BANK_W +: BANK_W]),
      .irq_o     (irq_o[n])
    );
  end

  assign sel_status = status_flat[bank_idx*BANK_W +: BANK_W];
  assign sel_enable = enable_flat[bank_idx*BANK_W +: BANK_W];

  always_comb begin
    reg_rdata_o = '0;
    if (cfg_sel) begin
      if (ent_ok) reg_rdata_o = tbl_rd_word;
    end else if (bank_ok) begin
      unique case (bank_off)
        OFF_EN_SET, OFF_EN_CLR: reg_rdata_o = sel_enable;
        OFF_RAW:                reg_rdata_o = sel_status;
        OFF_MASKED:             reg_rdata_o = sel_status & sel_enable;
        default:                reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_aggr_checker.sv
module evt_aggr_checker
  import evt_aggr_pkg::*;
#(
  parameter int unsigned NUM_VINT = 4,
  parameter int unsigned ADDR_W   = 17,
  localparam int unsigned VW = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       evt_valid_i,
  input logic                       evt_down_i,
  input logic                       reg_we_i,
  input logic [ADDR_W-1:0]          reg_addr_i,
  input logic [BANK_W-1:0]          reg_wdata_i,
  input logic                       map_hit,
  input logic [VW-1:0]              map_vint,
  input logic [BIT_W-1:0]           map_bit,
  input logic [NUM_VINT*BANK_W-1:0] status_flat,
  input logic [NUM_VINT*BANK_W-1:0] enable_flat
);
  logic bank_wr;
  logic en_set_q, en_clr_q, ev_set_q, drop_q;
  logic [VW-1:0] v_q;
  logic [BANK_W-1:0] wd_q;
  logic [VW-1:0] ev_v_q;
  logic [BIT_W-1:0] ev_b_q;
  logic [NUM_VINT*BANK_W-1:0] stat_prev_q;

  assign bank_wr = reg_we_i && !reg_addr_i[ADDR_W-1] &&
                   (32'(reg_addr_i[ADDR_W-2:12]) < NUM_VINT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_set_q <= 1'b0; en_clr_q <= 1'b0; ev_set_q <= 1'b0; drop_q <= 1'b0;
      v_q <= '0; wd_q <= '0; ev_v_q <= '0; ev_b_q <= '0; stat_prev_q <= '0;
    end else begin
      en_set_q    <= bank_wr && reg_addr_i[11:0] == OFF_EN_SET;
      en_clr_q    <= bank_wr && reg_addr_i[11:0] == OFF_EN_CLR;
      v_q         <= reg_addr_i[12 +: VW];
      wd_q        <= reg_wdata_i;
      ev_set_q    <= map_hit && !evt_down_i;
      ev_v_q      <= map_vint;
      ev_b_q      <= map_bit;
      drop_q      <= evt_valid_i && !map_hit && !reg_we_i;
      stat_prev_q <= status_flat;
    end
  end

  assert_enable_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_q |-> ((enable_flat[v_q*BANK_W +: BANK_W] & wd_q) == wd_q));

  assert_enable_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_q |-> ((enable_flat[v_q*BANK_W +: BANK_W] & wd_q) == '0));

  assert_event_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_set_q |-> status_flat[ev_v_q*BANK_W + 32'(ev_b_q)]);

  assert_drop_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |-> (status_flat == stat_prev_q));
endmodule

bind evt_aggr_top evt_aggr_checker #(.NUM_VINT(NUM_VINT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_down_i  (evt_down_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .map_hit     (map_hit),
  .map_vint    (map_vint),
  .map_bit     (map_bit),
  .status_flat (status_flat),
  .enable_flat (enable_flat)
);

// File: tb/evt_aggr_top_bench.sv
`timescale 1ns/1ps
module evt_aggr_top_bench;
  localparam int NV = 4;
  localparam int NE = 16;
  localparam int AW = 17;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_valid_i = 1'b0;
  logic [3:0] evt_num_i = '0;
  logic evt_down_i = 1'b0;
  logic reg_we_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;
  logic [NV-1:0] irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  evt_aggr_top #(.NUM_VINT(NV), .NUM_EVT(NE), .ADDR_W(AW)) u_evt_aggr_top (.*);

  // reference model
  logic [63:0] m_stat [NV];
  logic [63:0] m_en   [NV];
  logic [63:0] m_lvl  [NV];
  logic [31:0] m_tbl  [NE];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NV; i++) begin m_stat[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
      for (int i = 0; i < NE; i++) m_tbl[i] = 0;
    end else begin
      logic [31:0] ent;
      int ev_v, ev_b;
      bit ev_ok;
      ent = m_tbl[evt_num_i];
      ev_v = int'(ent[15:8]);
      ev_b = int'(ent[5:0]);
      ev_ok = evt_valid_i && ent[31] && ev_v < NV;
      if (reg_we_i) begin
        if (reg_addr_i[16]) begin
          int e;
          e = int'(reg_addr_i[15:3]);
          if (e < NE) begin
            m_tbl[e] = reg_wdata_i[31:0] & 32'h8001_FF3F;
            if (reg_wdata_i[31] && int'(reg_wdata_i[15:8]) < NV)
              m_lvl[int'(reg_wdata_i[15:8])][reg_wdata_i[5:0]] = reg_wdata_i[16];
          end
        end else begin
          int b;
          b = int'(reg_addr_i[15:12]);
          if (b < NV) begin
            case (reg_addr_i[11:0])
              12'h000: m_en[b] = m_en[b] | reg_wdata_i;
              12'h008: m_en[b] = m_en[b] & ~reg_wdata_i;
              12'h018: m_stat[b] = m_stat[b] & ~(reg_wdata_i & ~m_lvl[b]);
              default: ;
            endcase
          end
        end
      end
      if (ev_ok) begin
        if (!evt_down_i) m_stat[ev_v][ev_b] = 1'b1;
        else if (ent[16]) m_stat[ev_v][ev_b] = 1'b0;
      end
    end
  end

  function automatic logic [63:0] model_read(input logic [AW-1:0] a);
    int b, e;
    if (a[16]) begin
      e = int'(a[15:3]);
      return (e < NE) ? {32'h0, m_tbl[e]} : 64'h0;
    end
    b = int'(a[15:12]);
    if (b >= NV) return 64'h0;
    case (a[11:0])
      12'h000, 12'h008: return m_en[b];
      12'h018: return m_stat[b];
      12'h020: return m_stat[b] & m_en[b];
      default: return 64'h0;
    endcase
  endfunction

  // R9: irq compared on every falling edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      for (int v = 0; v < NV; v++) begin
        n_cmp++;
        if (irq_o[v] !== |(m_stat[v] & m_en[v])) begin
          n_bad++;
          $display("FAIL R9 irq[%0d] actual=%b expected=%b", v, irq_o[v], |(m_stat[v] & m_en[v]));
        end
      end
    end
  end

  function automatic logic [AW-1:0] bank_a(input int v, input int off);
    return AW'(v * 'h1000 + off);
  endfunction
  function automatic logic [AW-1:0] cfg_a(input int e);
    return AW'('h10000 + e * 8);
  endfunction
  function automatic logic [63:0] ent_w(input bit vld, input bit lvl, input int v, input int b);
    return {32'h0, vld, 14'h0, lvl, 8'(v), 2'b00, 6'(b)};
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 0; reg_wdata_i = '0;
  endtask

  task automatic ev(input int num, input bit down);
    evt_valid_i = 1; evt_num_i = 4'(num); evt_down_i = down;
    tick();
    evt_valid_i = 0; evt_down_i = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    logic [63:0] exp;
    reg_addr_i = a;
    #1;
    exp = model_read(a);
    n_cmp++;
    if (reg_rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata_o, exp);
    end
  endtask

  task automatic rd_abs(input logic [AW-1:0] a, input logic [63:0] exp, input string tag);
    reg_addr_i = a;
    #1;
    n_cmp++;
    if (reg_rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata_o, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    n_cmp++;
    if (irq_o !== '0) begin n_bad++; $display("FAIL R1 irq actual=%b expected=0", irq_o); end
    for (int v = 0; v < NV; v++) begin
      rd_abs(bank_a(v, 'h18), 64'h0, "R1 raw");
      rd_abs(bank_a(v, 'h0), 64'h0, "R1 enable");
    end
    rd_abs(cfg_a(3), 64'h0, "R1 entry");

    // R11 routing table
    wr(cfg_a(0), ent_w(1, 0, 0, 3));
    wr(cfg_a(1), ent_w(1, 1, 0, 10));
    wr(cfg_a(2), ent_w(1, 0, 2, 63));
    wr(cfg_a(3), ent_w(1, 1, 3, 0));
    wr(cfg_a(4), ent_w(0, 0, 1, 5));
    wr(cfg_a(5), ent_w(1, 0, 7, 2));
    wr(cfg_a(6), ent_w(1, 0, 1, 0) | 64'hFFFF_0000_007E_00C0);
    rd_abs(cfg_a(1), 64'h0000_0000_8001_000A, "R11 entry1");
    rd_abs(cfg_a(6), 64'h0000_0000_8000_0100 | 64'h0000_0000_007E_0000 & 64'h0001_0000, "R11 masked fields");
    rd(cfg_a(6), "R11 entry6");

    // R4 events, not yet enabled
    ev(0, 0);
    rd_abs(bank_a(0, 'h18), 64'h8, "R4 raw bit3");
    ev(1, 0);
    rd_abs(bank_a(0, 'h18), 64'h408, "R4 raw bits3,10");
    rd_abs(bank_a(0, 'h20), 64'h0, "R8 masked disabled");

    // R2 enable set
    wr(bank_a(0, 'h0), 64'h8);
    rd_abs(bank_a(0, 'h0), 64'h8, "R2 enable");
    rd_abs(bank_a(0, 'h20), 64'h8, "R8 masked");
    wr(bank_a(0, 'h0), 64'h0);
    rd_abs(bank_a(0, 'h8), 64'h8, "R2 zero write no effect");
    wr(bank_a(0, 'h0), 64'h400);
    rd(bank_a(0, 'h20), "R8 masked two");
    wr(bank_a(0, 'h20), 64'hFFFF);
    rd_abs(bank_a(0, 'h18), 64'h408, "R8 write masked ignored");

    // R6 acknowledge: edge cleared, level kept
    wr(bank_a(0, 'h18), 64'h408);
    rd_abs(bank_a(0, 'h18), 64'h400, "R6 ack");

    // R7 down events
    ev(0, 0);
    ev(0, 1);
    rd_abs(bank_a(0, 'h18), 64'h408, "R7 down on edge ignored");
    ev(1, 1);
    rd_abs(bank_a(0, 'h18), 64'h8, "R7 down clears level");

    // R10 set wins over same-cycle ack
    wr(bank_a(0, 'h18), 64'h8);
    rd_abs(bank_a(0, 'h18), 64'h0, "R10 precondition");
    evt_valid_i = 1; evt_num_i = 4'd0; evt_down_i = 0;
    reg_we_i = 1; reg_addr_i = bank_a(0, 'h18); reg_wdata_i = 64'h8;
    tick();
    evt_valid_i = 0; reg_we_i = 0; reg_wdata_i = '0;
    rd_abs(bank_a(0, 'h18), 64'h8, "R10 set wins");

    // R5 drops
    ev(4, 0);
    ev(5, 0);
    ev(9, 0);
    for (int v = 0; v < NV; v++) rd(bank_a(v, 'h18), "R5 dropped");
    rd_abs(bank_a(1, 'h18), 64'h0, "R5 invalid entry");

    // R12 bit 63 and bank isolation
    ev(2, 0);
    rd_abs(bank_a(2, 'h18), 64'h8000_0000_0000_0000, "R12 bit63");
    wr(bank_a(2, 'h0), 64'h8000_0000_0000_0000);
    rd_abs(bank_a(0, 'h0), 64'h408, "R12 other bank enable");
    n_cmp++;
    if (irq_o !== 4'b0101) begin n_bad++; $display("FAIL R12 irq actual=%b expected=0101", irq_o); end
    ev(3, 0);
    wr(bank_a(3, 'h0), 64'h1);
    wr(bank_a(3, 'h18), 64'h1);
    rd_abs(bank_a(3, 'h18), 64'h1, "R6 level bank3 kept");
    ev(3, 1);
    rd_abs(bank_a(3, 'h18), 64'h0, "R7 level bank3 down");

    // R3 enable clear
    wr(bank_a(0, 'h8), 64'h8);
    rd_abs(bank_a(0, 'h0), 64'h400, "R3 enable clear");
    wr(bank_a(2, 'h8), 64'hFFFF_FFFF_FFFF_FFFF);
    rd_abs(bank_a(2, 'h20), 64'h0, "R3 masked after clear");
    n_cmp++;
    if (irq_o[2] !== 1'b0) begin n_bad++; $display("FAIL R3 irq2 actual=%b expected=0", irq_o[2]); end

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule